// File: doc/BRIEF.md
# UART Receive Character Buffer with Line Status

This block stands between the receive shift register of a serial port and the host. Each time the shift register finishes a character it raises a one-cycle completion strobe carrying the byte and that character's parity-check result. The block queues the pair in a sixteen-entry first-in first-out store, so a parity flag stays attached to its own byte while characters move toward the host.

The host drains characters with a one-cycle pop strobe. The popped byte appears on the holding-register output one cycle later. Three status bits are always visible. Data-ready shows that at least one character is queued. Overrun is a sticky flag that records a character arriving while the store was full. Parity-error shows the flag of the character now at the head of the store. A one-cycle status-read strobe clears the sticky overrun bit. A character that arrives while the store is full is dropped, and the queued entries are left untouched.

Occupancy is tracked by a three-state machine. Its states are OCC_EMPTY, OCC_PARTIAL and OCC_FULL. It moves OCC_EMPTY to OCC_PARTIAL on a push. It moves OCC_PARTIAL to OCC_FULL on a push without a pop when fifteen characters are held. It moves OCC_PARTIAL to OCC_EMPTY on a pop without a push when one character is held. It moves OCC_FULL to OCC_PARTIAL on a pop without a push. In every other case it stays where it is. In OCC_EMPTY a pop is ignored. In OCC_FULL a push without a pop is refused and reported as an overrun.

Top module: `rx_line_fifo`

## Requirements
- R1: After reset, stat_ready, stat_overrun and stat_perr are 0 and rhr_data is 8'h00.
- R2: stat_ready is 1 exactly when at least one character is queued. It becomes 1 on the cycle after a char_done into an empty store and returns to 0 on the cycle after the last character is popped.
- R3: The store holds 16 characters, and they are read out in arrival order.
- R4: A char_done while 16 characters are held and no pop is requested is not stored. stat_overrun is 1 from the next cycle, and the queued characters are unchanged.
- R5: stat_overrun stays 1 until a host_stat_rd cycle and is 0 on the cycle after it. If a new overrun occurs in the same cycle as host_stat_rd, the bit stays 1.
- R6: stat_perr equals the parity flag stored with the character at the head of the store, and is 0 when the store is empty.
- R7: host_pop while characters are queued removes the head, and rhr_data shows the removed byte from the next cycle.
- R8: host_pop on an empty store leaves rhr_data unchanged and does not disturb the store; a later push followed by a pop returns the pushed byte.
- R9: char_done together with host_pop while 16 characters are held is accepted without overrun, and the store stays full with the new byte at its tail.
- R10: char_done together with host_pop on an empty store stores the new character, ignores the pop, and leaves rhr_data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | One-cycle strobe: a received character is complete |
| char_data | input | 8 | Byte of the completed character |
| char_perr | input | 1 | Parity check failed for the completed character |
| host_pop | input | 1 | One-cycle strobe: host reads the holding register |
| host_stat_rd | input | 1 | One-cycle strobe: host reads line status, clears overrun |
| rhr_data | output | 8 | Last byte popped by the host |
| stat_ready | output | 1 | At least one character queued |
| stat_overrun | output | 1 | Sticky: a character was dropped because the store was full |
| stat_perr | output | 1 | Parity flag of the head character |

## Verification
A wrong occupancy state appears at the ports right away. A pop then moves the read pointer when it should not, or a push is refused too early. Either one shows up as a wrong byte on rhr_data one cycle after the next pop, as stat_ready staying on or dropping too soon, or as stat_overrun rising before sixteen characters are held. A parity flag stored in the wrong slot shows as stat_perr disagreeing with the head byte in the very cycle that byte reaches the head. The full-store cases, a refused push and a swap of push and pop, are driven on purpose, so that a corrupted entry appears during the following drain.

// File: rtl/rx_line_pkg.sv
package rx_line_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    typedef struct packed {
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_occ_fsm.sv
module rx_occ_fsm
    import rx_line_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_req,
    input  logic pop_req,
    output logic push_ok,
    output logic pop_ok,
    output logic overrun_evt,
    output logic is_empty,
    output logic is_full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST_FREE = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT  = CNT_W'(1);

    occ_state_e       state_q, state_n;
    logic [CNT_W-1:0] count_q, count_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_n;
            count_q <= count_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_req) begin
                    state_n = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (push_req && !pop_req && count_q == LAST_FREE) begin
                    state_n = OCC_FULL;
                end else if (pop_req && !push_req && count_q == ONE_LEFT) begin
                    state_n = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (pop_req && !push_req) begin
                    state_n = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: state_n = OCC_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        push_ok     = 1'b0;
        pop_ok      = 1'b0;
        overrun_evt = 1'b0;
        is_empty    = 1'b0;
        is_full     = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
                is_empty = 1'b1;
                push_ok  = push_req;
            end
            OCC_PARTIAL: begin
                push_ok = push_req;
                pop_ok  = pop_req;
            end
            OCC_FULL: begin
                is_full     = 1'b1;
                pop_ok      = pop_req;
                push_ok     = push_req && pop_req;
                overrun_evt = push_req && !pop_req;
            end
            default: is_empty = 1'b1;
        endcase
        count_n = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

endmodule

// File: rtl/rx_entry_store.sv
module rx_entry_store
    import rx_line_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  rx_entry_t         wr_entry,
    input  logic              rd_en,
    output rx_entry_t         head_entry,
    output logic [CHAR_W-1:0] rhr_q
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    rx_entry_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            rhr_q  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_step(wr_ptr);
            if (rd_en) begin
                rd_ptr <= ptr_step(rd_ptr);
                rhr_q  <= slots[rd_ptr].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_ptr] <= wr_entry;
    end

    assign head_entry = slots[rd_ptr];

endmodule

// File: rtl/rx_sticky_flag.sv
module rx_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_evt) flag_q <= 1'b0;
    end

endmodule

// File: rtl/rx_line_fifo.sv
module rx_line_fifo
    import rx_line_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              host_pop,
    input  logic              host_stat_rd,
    output logic [CHAR_W-1:0] rhr_data,
    output logic              stat_ready,
    output logic              stat_overrun,
    output logic              stat_perr
);

    logic      push_ok, pop_ok, overrun_evt, fifo_empty, fifo_full;
    rx_entry_t head_entry, new_entry;

    assign new_entry = '{perr: char_perr, data: char_data};

    rx_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_req    (char_done),
        .pop_req     (host_pop),
        .push_ok     (push_ok),
        .pop_ok      (pop_ok),
        .overrun_evt (overrun_evt),
        .is_empty    (fifo_empty),
        .is_full     (fifo_full)
    );

    rx_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (push_ok),
        .wr_entry   (new_entry),
        .rd_en      (pop_ok),
        .head_entry (head_entry),
        .rhr_q      (rhr_data)
    );

    rx_sticky_flag u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (overrun_evt),
        .clr_evt (host_stat_rd),
        .flag_q  (stat_overrun)
    );

    assign stat_ready = !fifo_empty;
    assign stat_perr  = !fifo_empty && head_entry.perr;

endmodule

// File: rtl/rx_line_fifo_chk.sv
module rx_line_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       char_done,
    input logic       host_pop,
    input logic       host_stat_rd,
    input logic [7:0] rhr_data,
    input logic       stat_ready,
    input logic       stat_overrun,
    input logic       stat_perr,
    input logic       fifo_full
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!stat_ready && !stat_overrun && !stat_perr && rhr_data == 8'h00));

    assert_ready_on_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !stat_ready) |=> stat_ready);

    assert_full_implies_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> stat_ready);

    assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && char_done && !host_pop) |=> (stat_overrun && fifo_full));

    assert_overrun_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_overrun && !host_stat_rd) |=> stat_overrun);

    assert_overrun_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stat_rd && !(fifo_full && char_done && !host_pop)) |=> !stat_overrun);

    assert_perr_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_ready |-> !stat_perr);

    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_ready && host_pop) |=> $stable(rhr_data));

    assert_full_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && char_done && host_pop && !stat_overrun) |=> (!stat_overrun && fifo_full));

endmodule

bind rx_line_fifo rx_line_fifo_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .char_done    (char_done),
    .host_pop     (host_pop),
    .host_stat_rd (host_stat_rd),
    .rhr_data     (rhr_data),
    .stat_ready   (stat_ready),
    .stat_overrun (stat_overrun),
    .stat_perr    (stat_perr),
    .fifo_full    (fifo_full)
);

// File: tb/rx_line_fifo_tb.sv
`timescale 1ns/1ps
module rx_line_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_done = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_perr = 1'b0;
    logic       host_pop = 1'b0;
    logic       host_stat_rd = 1'b0;
    logic [7:0] rhr_data;
    logic       stat_ready, stat_overrun, stat_perr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_line_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
        .char_perr(char_perr), .host_pop(host_pop), .host_stat_rd(host_stat_rd),
        .rhr_data(rhr_data), .stat_ready(stat_ready), .stat_overrun(stat_overrun),
        .stat_perr(stat_perr)
    );

    typedef struct packed {
        logic       push;
        logic [7:0] d;
        logic       pe;
        logic       pop;
        logic       srd;
        logic       e_rdy;
        logic       e_ovr;
        logic       e_pe;
        logic [7:0] e_rhr;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R2 push into empty
        '{1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R6 head still A5
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5}, // R7 pop, head 3C
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C}, // R2 last pop
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C}, // R8 empty pop
        '{1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C}, // R10 push+pop empty
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C}, // R5 status read idle
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77}  // R8 pushed byte returns
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at falling edge, pass one rising edge, return at next falling edge
    task automatic step(input logic push, input logic [7:0] d, input logic pe,
                        input logic pop, input logic srd);
        char_done = push; char_data = d; char_perr = pe;
        host_pop = pop; host_stat_rd = srd;
        @(negedge clk);
        char_done = 1'b0; host_pop = 1'b0; host_stat_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", stat_ready, 0);
        check("R1 overrun", stat_overrun, 0);
        check("R1 perr", stat_perr, 0);
        check("R1 rhr", rhr_data, 0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].push, VEC[i].d, VEC[i].pe, VEC[i].pop, VEC[i].srd);
            check($sformatf("R2 vec%0d ready", i), stat_ready, VEC[i].e_rdy);
            check($sformatf("R5 vec%0d overrun", i), stat_overrun, VEC[i].e_ovr);
            check($sformatf("R6 vec%0d perr", i), stat_perr, VEC[i].e_pe);
            check($sformatf("R7 vec%0d rhr", i), rhr_data, VEC[i].e_rhr);
        end

        // R3 fill sixteen
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 8'h10 + 8'(i), i[0], 1'b0, 1'b0);
            check("R4 no overrun while filling", stat_overrun, 0);
        end
        check("R3 ready when full", stat_ready, 1);
        // R4 refused push
        step(1'b1, 8'hEE, 1'b1, 1'b0, 1'b0);
        check("R4 overrun set", stat_overrun, 1);
        check("R4 head perr intact", stat_perr, 0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R5 overrun held", stat_overrun, 1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R5 overrun cleared", stat_overrun, 0);
        // R9 swap on full
        step(1'b1, 8'h99, 1'b1, 1'b1, 1'b0);
        check("R9 no overrun", stat_overrun, 0);
        check("R9 rhr head", rhr_data, 8'h10);
        check("R9 head perr", stat_perr, 1);
        // drain: 11..1F then 99, EE absent
        for (int k = 1; k <= 16; k++) begin
            logic [7:0] exp_d;
            logic       exp_p;
            exp_d = (k == 16) ? 8'h99 : 8'h10 + 8'(k);
            exp_p = (k == 16) ? 1'b1 : k[0];
            check("R6 head perr", stat_perr, exp_p);
            check("R3 ready before pop", stat_ready, 1);
            step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
            check("R3 order", rhr_data, exp_d);
        end
        check("R4 dropped byte absent", stat_ready, 0);

        // R5 set wins over status read
        for (int i = 0; i < 16; i++) step(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'hEE, 1'b0, 1'b0, 1'b1);
        check("R5 set beats clear", stat_overrun, 1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R5 clear after read", stat_overrun, 0);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R4 first byte kept", rhr_data, 8'h40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule